// File: doc/BRIEF.md
# Cache-Line Store Backup Queue

This block keeps an ordered record of stores that a cache-allocating move makes to cacheable addresses. When software later invalidates a cache line, every recorded store that falls in that 32-byte line is written out to memory. The writes go in the order the stores were recorded, and those entries then leave the queue. A discard strobe drops every recorded store at once.

Recording is a single-cycle append at the tail. Invalidation is a scan that visits one entry per clock. Matching entries are offered on a valid/ready memory write port. Entries that do not match are compacted toward the head in their original order, so the tail is correct once the scan ends. The block raises `busy` for the whole scan. Storage depth is a parameter.

Top module: `stbk_queue`

## Requirements
- R1: After reset `busy`, `mem_valid` and `overflow` are low and the queue holds no entries, so an invalidate produces no memory writes.
- R2: A record request taken while idle with `rec_cacheable`=1 appends {address, data} at the tail. With `rec_cacheable`=0 nothing is stored.
- R3: An invalidate replays every entry whose address equals the request address in bits [AW-1:5]. Bits [4:0] are ignored. Each write carries the recorded address and data, and the writes follow recording order.
- R4: Replayed entries are removed, so a second invalidate of the same line produces no writes.
- R5: Entries outside the invalidated line stay queued in their original order. Records made after the scan are appended behind them.
- R6: `discard` empties the queue in the next cycle. It takes priority over a record in the same cycle, and it aborts a running scan: `busy` and `mem_valid` are low in the following cycle.
- R7: `busy` is high from the cycle after an accepted invalidate until the scan ends. With `mem_ready` held high, a scan over N queued entries keeps `busy` high for N+1 cycles. Record and invalidate requests are ignored while `busy` is high.
- R8: A cacheable record request that finds the queue full (DEPTH entries) is dropped and sets `overflow`. The flag stays high until reset, including across discards.
- R9: A write is consumed only in a cycle with `mem_valid` and `mem_ready` both high. While `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold steady.
- R10: A record and an invalidate that arrive together while idle are both taken. The record is appended first, and the scan includes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Record request strobe |
| rec_addr | input | AW | Store address to record |
| rec_data | input | DW | Store data to record |
| rec_cacheable | input | 1 | Target address is cacheable |
| inv_valid | input | 1 | Line invalidate request strobe |
| inv_addr | input | AW | Address inside the line to invalidate |
| discard | input | 1 | Drop all recorded stores |
| mem_valid | output | 1 | Replayed write offered |
| mem_addr | output | AW | Replayed write address |
| mem_data | output | DW | Replayed write data |
| mem_ready | input | 1 | Memory accepts the offered write |
| busy | output | 1 | Invalidate scan in progress |
| overflow | output | 1 | Sticky: a cacheable record was dropped when full |

## Verification
Any corruption of the stored entries, the count or the compaction shows up at the write port during the next invalidate of the affected line. It appears as a missing write, an extra write, a wrong address or data, or writes out of order. A tail pointer that is not repaired corrupts the order of the following scan. A wrong count also changes the length of the `busy` window by at least one cycle in that scan. The bench therefore follows every state-changing sequence with invalidates that read the queue back in full, and it checks the scan length against the model's entry count.

// File: rtl/stbk_queue.sv
module stbk_queue #(
  parameter int DEPTH     = 8,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LINE_BITS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_valid,
  input  logic [AW-1:0] rec_addr,
  input  logic [DW-1:0] rec_data,
  input  logic          rec_cacheable,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_addr,
  input  logic          discard,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ready,
  output logic          busy,
  output logic          overflow
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TW = AW - LINE_BITS;

  logic [AW-1:0] q_addr [DEPTH];
  logic [DW-1:0] q_data [DEPTH];
  logic [CW-1:0] cnt, rd, wr;
  logic [TW-1:0] line_q;
  logic          busy_q, ovf_q;

  wire [IW-1:0] rd_i = rd[IW-1:0];
  wire [IW-1:0] wr_i = wr[IW-1:0];
  wire [IW-1:0] cnt_i = cnt[IW-1:0];
  wire          live = busy_q && (rd < cnt);
  wire          hit  = (q_addr[rd_i][AW-1:LINE_BITS] == line_q);
  wire          full = (cnt == CW'(DEPTH));

  assign mem_valid = live && hit;
  assign mem_addr  = q_addr[rd_i];
  assign mem_data  = q_data[rd_i];
  assign busy      = busy_q;
  assign overflow  = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      rd     <= '0;
      wr     <= '0;
      line_q <= '0;
      busy_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (discard) begin
      cnt    <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (!live) begin
        cnt    <= wr;
        busy_q <= 1'b0;
      end else if (hit) begin
        if (mem_ready) rd <= rd + 1'b1;
      end else begin
        q_addr[wr_i] <= q_addr[rd_i];
        q_data[wr_i] <= q_data[rd_i];
        wr <= wr + 1'b1;
        rd <= rd + 1'b1;
      end
    end else begin
      if (rec_valid && rec_cacheable) begin
        if (!full) begin
          q_addr[cnt_i] <= rec_addr;
          q_data[cnt_i] <= rec_data;
          cnt <= cnt + 1'b1;
        end else begin
          ovf_q <= 1'b1;
        end
      end
      if (inv_valid) begin
        busy_q <= 1'b1;
        rd     <= '0;
        wr     <= '0;
        line_q <= inv_addr[AW-1:LINE_BITS];
      end
    end
  end
endmodule

// File: rtl/stbk_queue_chk.sv
module stbk_queue_chk #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LINE_BITS = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inv_valid,
  input logic [AW-1:0] inv_addr,
  input logic          discard,
  input logic          mem_valid,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic          mem_ready,
  input logic          busy,
  input logic          overflow
);
  logic [AW-LINE_BITS-1:0] line_c;

  always_ff @(posedge clk) begin
    if (!rst_n) line_c <= '0;
    else if (inv_valid && !busy && !discard) line_c <= inv_addr[AW-1:LINE_BITS];
  end

  AST_LINE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[AW-1:LINE_BITS] == line_c)); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !discard) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R8
  AST_DISCARD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> (!busy && !mem_valid)); // R6
  AST_VALID_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy); // R7
  AST_INV_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !busy && !discard) |=> busy); // R7
endmodule

bind stbk_queue stbk_queue_chk #(.AW(AW), .DW(DW), .LINE_BITS(LINE_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .inv_valid(inv_valid), .inv_addr(inv_addr),
  .discard(discard), .mem_valid(mem_valid), .mem_addr(mem_addr),
  .mem_data(mem_data), .mem_ready(mem_ready), .busy(busy), .overflow(overflow)
);

// File: tb/stbk_queue_tb.sv
module stbk_queue_tb_top;
  localparam int DEPTH = 4;
  localparam int NV    = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0, rec_cacheable = 1'b0, inv_valid = 1'b0, discard = 1'b0;
  logic [31:0] rec_addr = '0, rec_data = '0, inv_addr = '0;
  logic        mem_ready = 1'b1;
  logic        mem_valid, busy, overflow;
  logic [31:0] mem_addr, mem_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [63:0] mq[$];

  always #10 clk = ~clk;

  stbk_queue #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_addr(rec_addr),
    .rec_data(rec_data), .rec_cacheable(rec_cacheable), .inv_valid(inv_valid),
    .inv_addr(inv_addr), .discard(discard), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .busy(busy), .overflow(overflow)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] a;
    logic [31:0] d;
    logic        c;
    logic [3:0]  n;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{2'd0, 32'h1000, 32'h11, 1'b1, 4'd0},
    '{2'd0, 32'h2004, 32'h22, 1'b1, 4'd0},
    '{2'd0, 32'h1010, 32'h33, 1'b1, 4'd0},
    '{2'd0, 32'h101C, 32'h44, 1'b0, 4'd0},
    '{2'd1, 32'h1008, 32'h0,  1'b0, 4'd2},
    '{2'd0, 32'h3000, 32'h55, 1'b1, 4'd0},
    '{2'd1, 32'h2000, 32'h0,  1'b0, 4'd1},
    '{2'd1, 32'h1000, 32'h0,  1'b0, 4'd0},
    '{2'd1, 32'h3010, 32'h0,  1'b0, 4'd1},
    '{2'd0, 32'h4000, 32'h66, 1'b1, 4'd0},
    '{2'd0, 32'h4020, 32'h77, 1'b1, 4'd0},
    '{2'd2, 32'h0,    32'h0,  1'b0, 4'd0},
    '{2'd1, 32'h4000, 32'h0,  1'b0, 4'd0},
    '{2'd1, 32'h4020, 32'h0,  1'b0, 4'd0},
    '{2'd0, 32'h101F, 32'h88, 1'b1, 4'd0},
    '{2'd0, 32'h1020, 32'h99, 1'b1, 4'd0},
    '{2'd1, 32'h1000, 32'h0,  1'b0, 4'd1},
    '{2'd1, 32'h1020, 32'h0,  1'b0, 4'd1},
    '{2'd0, 32'h5000, 32'hA1, 1'b1, 4'd0},
    '{2'd0, 32'h6000, 32'hB1, 1'b1, 4'd0},
    '{2'd0, 32'h5004, 32'hC1, 1'b1, 4'd0},
    '{2'd0, 32'h6004, 32'hD1, 1'b1, 4'd0},
    '{2'd1, 32'h5000, 32'h0,  1'b0, 4'd2},
    '{2'd0, 32'h6008, 32'hE1, 1'b1, 4'd0},
    '{2'd1, 32'h6000, 32'h0,  1'b0, 4'd3}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit same_line(input logic [31:0] x, input logic [31:0] y);
    return x[31:5] == y[31:5];
  endfunction

  task automatic model_rec(input logic [31:0] a, input logic [31:0] d, input logic c);
    if (c) begin
      if (mq.size() < DEPTH) mq.push_back({a, d});
    end
  endtask

  task automatic do_rec(input logic [31:0] a, input logic [31:0] d, input logic c);
    @(negedge clk);
    rec_valid = 1'b1; rec_addr = a; rec_data = d; rec_cacheable = c;
    model_rec(a, d, c);
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic do_discard();
    @(negedge clk);
    discard = 1'b1;
    @(negedge clk);
    discard = 1'b0;
    mq.delete();
  endtask

  // invalidate with mem_ready high; optional record in the same cycle (R10)
  task automatic run_inv(input logic [31:0] a, input bit with_rec, input logic [31:0] ra,
                         input logic [31:0] rdat, output int nw);
    logic [63:0] hits[$];
    logic [63:0] keep[$];
    int cyc = 0;
    int n = 0;
    int sz;
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = a;
    if (with_rec) begin
      rec_valid = 1'b1; rec_addr = ra; rec_data = rdat; rec_cacheable = 1'b1;
      model_rec(ra, rdat, 1'b1);
    end
    sz = mq.size();
    foreach (mq[i]) begin
      if (same_line(mq[i][63:32], a)) hits.push_back(mq[i]);
      else keep.push_back(mq[i]);
    end
    @(negedge clk);
    inv_valid = 1'b0; rec_valid = 1'b0;
    while (busy && cyc < 1000) begin
      cyc++;
      if (mem_valid && mem_ready) begin
        chk(n < hits.size() && {mem_addr, mem_data} == hits[n], "R3 replayed write/order",
            {mem_addr, mem_data}, hits[n]);
        n++;
      end
      @(negedge clk);
    end
    chk(n == hits.size(), "R4 number of replayed writes", 64'(n), 64'(hits.size()));
    chk(cyc == sz + 1, "R7 busy window length", 64'(cyc), 64'(sz + 1));
    mq = keep;
    nw = n;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int nw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_valid && !overflow, "R1 reset outputs", {busy, mem_valid, overflow}, 3'b000);
    run_inv(32'h0, 1'b0, 32'h0, 32'h0, nw);
    chk(nw == 0, "R1 empty after reset", 64'(nw), 0);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      case (VT[i].op)
        2'd0: do_rec(VT[i].a, VT[i].d, VT[i].c);
        2'd1: begin
          run_inv(VT[i].a, 1'b0, 32'h0, 32'h0, nw);
          chk(nw == int'(VT[i].n), "R2/R5 vector write count", 64'(nw), 64'(VT[i].n));
        end
        default: begin
          do_discard();
          chk(!busy && !mem_valid, "R6 idle after discard", {busy, mem_valid}, 2'b00);
        end
      endcase
    end
    do_discard();

    // R10 record and invalidate in the same cycle
    do_rec(32'h7000, 32'h71, 1'b1);
    run_inv(32'h7000, 1'b1, 32'h7008, 32'h72, nw);
    chk(nw == 2, "R10 same-cycle record included", 64'(nw), 2);

    // R7 requests ignored while busy
    do_rec(32'h7100, 32'h1, 1'b1);
    do_rec(32'h7104, 32'h2, 1'b1);
    do_rec(32'h7108, 32'h3, 1'b1);
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = 32'h7100;
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = 32'h8000;
    rec_valid = 1'b1; rec_addr = 32'h8000; rec_data = 32'h80; rec_cacheable = 1'b1;
    chk(busy, "R7 busy during scan", busy, 1);
    @(negedge clk);
    inv_valid = 1'b0; rec_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(!busy, "R7 invalidate during scan ignored", busy, 0);
    mq.delete();
    run_inv(32'h8000, 1'b0, 32'h0, 32'h0, nw);
    chk(nw == 0, "R7 record during scan ignored", 64'(nw), 0);

    // R9 stall holds the offered write
    do_rec(32'h9000, 32'h91, 1'b1);
    do_rec(32'h9004, 32'h92, 1'b1);
    mem_ready = 1'b0;
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = 32'h9000;
    @(negedge clk);
    inv_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(mem_valid && mem_addr == 32'h9000 && mem_data == 32'h91, "R9 held while not ready",
          {mem_addr, mem_data}, {32'h9000, 32'h91});
      @(negedge clk);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    chk(mem_valid && mem_addr == 32'h9004 && mem_data == 32'h92, "R9 next after accept",
        {mem_addr, mem_data}, {32'h9004, 32'h92});
    @(negedge clk);
    @(negedge clk);
    chk(!busy && !mem_valid, "R9 scan finished", {busy, mem_valid}, 2'b00);
    mq.delete();

    // R6 discard aborts a scan
    do_rec(32'hA000, 32'hA1, 1'b1);
    do_rec(32'hA004, 32'hA2, 1'b1);
    mem_ready = 1'b0;
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = 32'hA000;
    @(negedge clk);
    inv_valid = 1'b0;
    discard = 1'b1;
    @(negedge clk);
    discard = 1'b0;
    chk(!busy && !mem_valid, "R6 scan aborted", {busy, mem_valid}, 2'b00);
    mem_ready = 1'b1;
    mq.delete();
    run_inv(32'hA000, 1'b0, 32'h0, 32'h0, nw);
    chk(nw == 0, "R6 queue empty after abort", 64'(nw), 0);

    // R6 discard beats a record in the same cycle
    @(negedge clk);
    discard = 1'b1; rec_valid = 1'b1; rec_addr = 32'hA100; rec_data = 32'h5; rec_cacheable = 1'b1;
    @(negedge clk);
    discard = 1'b0; rec_valid = 1'b0;
    run_inv(32'hA100, 1'b0, 32'h0, 32'h0, nw);
    chk(nw == 0, "R6 discard wins over record", 64'(nw), 0);

    // R8 overflow when full
    for (int k = 0; k < DEPTH; k++) do_rec(32'hB000 + 32'(4 * k), 32'(k + 1), 1'b1);
    chk(!overflow, "R8 no overflow at exactly full", overflow, 0);
    do_rec(32'hB100, 32'hBB, 1'b0);
    chk(!overflow, "R8 non-cacheable when full", overflow, 0);
    do_rec(32'hB100, 32'hBB, 1'b1);
    chk(overflow, "R8 overflow set", overflow, 1);
    run_inv(32'hB100, 1'b0, 32'h0, 32'h0, nw);
    chk(nw == 0, "R8 dropped record absent", 64'(nw), 0);
    run_inv(32'hB000, 1'b0, 32'h0, 32'h0, nw);
    chk(nw == DEPTH, "R8 full contents replayed", 64'(nw), 64'(DEPTH));
    do_discard();
    chk(overflow, "R8 overflow sticky across discard", overflow, 1);

    // R1 reset clears overflow
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!overflow && !busy, "R1 reset clears flags", {overflow, busy}, 2'b00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule